// File: doc/BRIEF.md
# Pseudo-SRAM Power-State Sequencer

This clocked block steers a pseudo-SRAM through its power states: the mandatory settling wait once the supply is good, the normal usable state, and the deep power-down cycle that is entered and left through the memory's active-low power-down pin. During every interval in which the memory must not be touched, it forces the chip-select inhibit high. It tells the access controller through a single ready flag when the memory may be used.

Refresh inside the memory stops while it is powered down. Every exit from deep power-down therefore raises a sticky flag, which the host clears once it has reloaded whatever it needs. A power-down request is taken only when the access controller reports idle. A wake request is honoured only after the minimum power-down pulse has elapsed, and a wake that comes early is remembered until then. All wait lengths are given in nanoseconds and are turned into clock cycles, rounded up, from a clock-period parameter.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is active, the outputs are dpd_n_o=1, cs_block_o=1, ready_o=0 and data_lost_o=0.
- R2: After supply_ok_i has been high without a break for PU_CYC = ceil(T_PWRUP_NS*1000/CLK_PERIOD_PS) rising edges, ready_o rises and cs_block_o falls on the PU_CYC-th edge, and not earlier.
- R3: supply_ok_i low drops ready_o at once. From the next edge it holds cs_block_o=1 and dpd_n_o=1 and restarts the power-up count from zero. data_lost_o is left unchanged.
- R4: While acc_idle_i is low, a power-down request has no effect: ready_o stays high and dpd_n_o stays high.
- R5: In the ready state, when pd_req_i and acc_idle_i are both high, ready_o goes low in the same cycle. cs_block_o rises on the next edge while dpd_n_o is still high, and dpd_n_o falls on the edge after that.
- R6: dpd_n_o falls only when cs_block_o was already high in the cycle before. cs_block_o stays high for as long as dpd_n_o is low.
- R7: dpd_n_o stays low for at least ZZ_CYC = ceil(T_ZZ_MIN_NS*1000/CLK_PERIOD_PS) cycles. A wake_req_i pulse seen during the entry cycle or during that minimum is held, and dpd_n_o then rises exactly ZZ_CYC cycles after it fell.
- R8: Once the minimum has elapsed, dpd_n_o stays low until wake_req_i is sampled high, and it rises on that edge.
- R9: After dpd_n_o rises, cs_block_o stays high and ready_o low for REC_CYC = ceil(T_RECOVER_NS*1000/CLK_PERIOD_PS) cycles. ready_o then rises and cs_block_o falls.
- R10: data_lost_o is set on the edge on which dpd_n_o rises after a power-down. It stays set until lost_ack_i is sampled high, and setting takes priority over clearing.
- R11: pd_req_i outside the ready state and wake_req_i outside the power-down states are ignored and are not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Memory supply has reached its minimum |
| pd_req_i | input | 1 | Request to enter deep power-down |
| acc_idle_i | input | 1 | Access controller has no transfer in flight |
| wake_req_i | input | 1 | Request to leave deep power-down |
| lost_ack_i | input | 1 | Host acknowledge that clears data_lost_o |
| dpd_n_o | output | 1 | Deep power-down pin to the memory, active low |
| cs_block_o | output | 1 | Forces the memory chip select inactive (high) |
| ready_o | output | 1 | Memory may be accessed |
| data_lost_o | output | 1 | Sticky: contents invalid after a power-down exit |

## Verification
The bench builds the sequencer with a 10 ns clock, a 400 ns power-up wait, a 300 ns recovery and a 45 ns minimum pulse. These give 40, 30 and 5 cycles, and the 45 ns value exercises the round-up of a fraction of a cycle. At these lengths the bench can cover two complete power-down cycles, a supply drop both during the power-up wait and in the ready state, and a long power-down that outlasts the minimum, all within a few hundred cycles. It can also check every wait boundary on its exact edge.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_READY,
    ST_DPD_ENTER,
    ST_DPD,
    ST_RECOVER
  } pwr_state_e;

  // nanoseconds to clock cycles, rounded up, at least one
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ps);
    longint unsigned num;
    num = (64'(t_ns) * 64'd1000 + 64'(clk_ps) - 64'd1) / 64'(clk_ps);
    return (num == 64'd0) ? 32'd1 : 32'(num);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  // saturates at limit-1; restart on clr
  assign hit_o = (cnt_q >= (limit_i - CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!hit_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  p_timer_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !clr_i) |=> (cnt_q == $past(cnt_q)));

  p_timer_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/psram_wake_hold.sv
module psram_wake_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic wake_i,
  output logic pend_o
);

  logic wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wake_q <= 1'b0;
    else if (!arm_i) wake_q <= 1'b0;
    else if (wake_i) wake_q <= 1'b1;
  end

  assign pend_o = arm_i & (wake_q | wake_i);

  p_wake_unarmed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !wake_q);

endmodule

// File: rtl/psram_lost_flag.sv
module psram_lost_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic lost_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lost_o <= 1'b0;
    else if (set_i)  lost_o <= 1'b1;
    else if (ack_i)  lost_o <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> lost_o);

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_PWRUP_NS    = 200000,
  parameter int unsigned T_RECOVER_NS  = 200000,
  parameter int unsigned T_ZZ_MIN_NS   = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic pd_req_i,
  input  logic acc_idle_i,
  input  logic wake_req_i,
  input  logic lost_ack_i,
  output logic dpd_n_o,
  output logic cs_block_o,
  output logic ready_o,
  output logic data_lost_o
);

  localparam int unsigned PU_CYC  = ns_to_cycles(T_PWRUP_NS, CLK_PERIOD_PS);
  localparam int unsigned REC_CYC = ns_to_cycles(T_RECOVER_NS, CLK_PERIOD_PS);
  localparam int unsigned ZZ_CYC  = ns_to_cycles(T_ZZ_MIN_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC = max3(PU_CYC, REC_CYC, ZZ_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  pwr_state_e       state_q, state_d;
  logic             pd_accept;
  logic             tmr_clr, tmr_hit;
  logic [CNT_W-1:0] tmr_limit;
  logic             wake_arm, wake_pend;
  logic             lost_set;
  logic             dpd_n_q, cs_block_q;

  assign pd_accept = supply_ok_i && (state_q == ST_READY) && pd_req_i && acc_idle_i;

  always_comb begin
    state_d = state_q;
    if (!supply_ok_i) begin
      state_d = ST_PWRUP;
    end else begin
      unique case (state_q)
        ST_PWRUP:     if (tmr_hit) state_d = ST_READY;
        ST_READY:     if (pd_accept) state_d = ST_DPD_ENTER;
        ST_DPD_ENTER: state_d = ST_DPD;
        ST_DPD:       if (tmr_hit && wake_pend) state_d = ST_RECOVER;
        ST_RECOVER:   if (tmr_hit) state_d = ST_READY;
        default:      state_d = ST_PWRUP;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PWRUP:   tmr_limit = CNT_W'(PU_CYC);
      ST_DPD:     tmr_limit = CNT_W'(ZZ_CYC);
      ST_RECOVER: tmr_limit = CNT_W'(REC_CYC);
      default:    tmr_limit = CNT_W'(1);
    endcase
  end

  assign tmr_clr  = (state_d != state_q) || !supply_ok_i;
  assign wake_arm = (state_q == ST_DPD_ENTER) || (state_q == ST_DPD);
  assign lost_set = (state_q == ST_DPD) && (state_d == ST_RECOVER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PWRUP;
      dpd_n_q    <= 1'b1;
      cs_block_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      dpd_n_q    <= (state_d != ST_DPD);
      cs_block_q <= (state_d != ST_READY);
    end
  end

  psram_wait_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .limit_i (tmr_limit),
    .hit_o   (tmr_hit)
  );

  psram_wake_hold i_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (wake_arm),
    .wake_i (wake_req_i),
    .pend_o (wake_pend)
  );

  psram_lost_flag i_lost (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (lost_set),
    .ack_i  (lost_ack_i),
    .lost_o (data_lost_o)
  );

  assign dpd_n_o    = dpd_n_q;
  assign cs_block_o = cs_block_q;
  assign ready_o    = (state_q == ST_READY) && !pd_accept && supply_ok_i;

  // cycles spent with the power-down pin low, for the pulse check
  logic [CNT_W-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         low_run_q <= '0;
    else if (dpd_n_q)                    low_run_q <= '0;
    else if (low_run_q != {CNT_W{1'b1}}) low_run_q <= low_run_q + CNT_W'(1);
  end

  p_cs_before_dpd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dpd_n_q) |-> $past(cs_block_q));

  p_cs_held_dpd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dpd_n_q |-> cs_block_q);

  p_ready_usable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!cs_block_o && dpd_n_o));

  p_min_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dpd_n_q) && $past(supply_ok_i)) |-> (low_run_q >= CNT_W'(ZZ_CYC)));

  p_lost_on_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dpd_n_q) && $past(supply_ok_i)) |-> data_lost_o);

  p_pwrup_blocked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWRUP) |-> (cs_block_q && !ready_o));

endmodule

// File: tb/test_psram_pwr_seq.sv
module test_psram_pwr_seq;

  localparam int TB_CLK_NS = 10;
  localparam int P = 40;  // 400 ns
  localparam int R = 30;  // 300 ns
  localparam int Z = 5;   // 45 ns rounded up

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0, pd_req = 1'b0, acc_idle = 1'b0, wake_req = 1'b0, lost_ack = 1'b0;
  logic dpd_n, cs_block, ready, data_lost;

  psram_pwr_seq #(
    .CLK_PERIOD_PS (TB_CLK_NS * 1000),
    .T_PWRUP_NS    (400),
    .T_RECOVER_NS  (300),
    .T_ZZ_MIN_NS   (45)
  ) i_psram_pwr_seq (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok),
    .pd_req_i    (pd_req),
    .acc_idle_i  (acc_idle),
    .wake_req_i  (wake_req),
    .lost_ack_i  (lost_ack),
    .dpd_n_o     (dpd_n),
    .cs_block_o  (cs_block),
    .ready_o     (ready),
    .data_lost_o (data_lost)
  );

  always #(TB_CLK_NS / 2) clk = ~clk;

  typedef struct {
    int         cyc;
    logic [3:0] exp;  // {dpd_n, cs_block, ready, data_lost}
    string      tag;
  } item_t;

  item_t sb_q[$];
  int edge_cnt = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [3:0] obs();
    return {dpd_n, cs_block, ready, data_lost};
  endfunction

  task automatic compare(logic [3:0] exp, string tag);
    checks++;
    if (obs() !== exp) begin
      failures++;
      $display("FAIL %s edge=%0d actual=%b expected=%b", tag, edge_cnt, obs(), exp);
    end
  endtask

  task automatic expect_span(int from, int to, logic [3:0] v, string tag);
    for (int k = from; k <= to; k++) sb_q.push_back('{edge_cnt + k, v, tag});
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      edge_cnt++;
      #2;
      for (int i = sb_q.size() - 1; i >= 0; i--) begin
        if (sb_q[i].cyc == edge_cnt) begin
          compare(sb_q[i].exp, sb_q[i].tag);
          sb_q.delete(i);
        end else if (sb_q[i].cyc < edge_cnt) begin
          checks++;
          failures++;
          $display("FAIL %s missed edge=%0d actual=%b expected=%b",
                   sb_q[i].tag, sb_q[i].cyc, obs(), sb_q[i].exp);
          sb_q.delete(i);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(2);
    compare(4'b1100, "R1");
    rst_ni = 1'b1;
    cyc(1);
    // supply absent: stay blocked
    expect_span(1, 8, 4'b1100, "R3");
    cyc(8);
    // power-up wait interrupted by a supply drop
    supply_ok = 1'b1;
    expect_span(1, 9, 4'b1100, "R2");
    cyc(10);
    supply_ok = 1'b0;
    expect_span(1, 3, 4'b1100, "R3");
    cyc(3);
    supply_ok = 1'b1;
    expect_span(1, P - 1, 4'b1100, "R2");
    expect_span(P, P, 4'b1010, "R2");
    cyc(P);
    // request while access controller busy
    pd_req = 1'b1;
    #1 compare(4'b1010, "R4");
    expect_span(1, 5, 4'b1010, "R4");
    cyc(5);
    // accept; early one-cycle wake in the entry cycle
    acc_idle = 1'b1;
    #1 compare(4'b1000, "R5");
    expect_span(1, 1, 4'b1100, "R5");
    expect_span(2, 1 + Z, 4'b0100, "R7");
    expect_span(2 + Z, 2 + Z, 4'b1101, "R10");
    expect_span(3 + Z, 1 + Z + R, 4'b1101, "R9");
    expect_span(2 + Z + R, 2 + Z + R, 4'b1011, "R9");
    cyc(1);
    pd_req = 1'b0;
    acc_idle = 1'b0;
    wake_req = 1'b1;
    cyc(1);
    wake_req = 1'b0;
    cyc(Z + R);
    // acknowledge clears the flag
    lost_ack = 1'b1;
    expect_span(1, 1, 4'b1010, "R10");
    cyc(1);
    lost_ack = 1'b0;
    // wake in ready state is ignored
    wake_req = 1'b1;
    expect_span(1, 3, 4'b1010, "R11");
    cyc(3);
    wake_req = 1'b0;
    // long power-down, wake well after the minimum
    pd_req = 1'b1;
    acc_idle = 1'b1;
    expect_span(1, 1, 4'b1100, "R5");
    expect_span(2, 21, 4'b0100, "R8");
    cyc(1);
    pd_req = 1'b0;
    acc_idle = 1'b0;
    cyc(20);
    wake_req = 1'b1;
    expect_span(1, 1, 4'b1101, "R8");
    cyc(1);
    wake_req = 1'b0;
    // request during recovery is ignored
    pd_req = 1'b1;
    acc_idle = 1'b1;
    expect_span(1, R - 1, 4'b1101, "R11");
    cyc(5);
    pd_req = 1'b0;
    acc_idle = 1'b0;
    expect_span(R - 5, R - 5, 4'b1011, "R9");
    cyc(R - 5);
    // supply loss in ready state; flag kept
    supply_ok = 1'b0;
    #1 compare(4'b1001, "R3");
    expect_span(1, 3, 4'b1101, "R3");
    cyc(3);
    supply_ok = 1'b1;
    expect_span(1, P - 1, 4'b1101, "R3");
    expect_span(P, P, 4'b1011, "R2");
    cyc(P + 2);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb_q.size());
    end
    finish_run();
  end

endmodule